// File: doc/BRIEF.md
# Host Event SMI/SCI Signaller

This block converts three classes of host-event bit vectors into the sideband notification lines an embedded controller raises toward its host chipset. An accepted update strobe refreshes two pending flags, one for the SMI class and one for the SCI class. It can also start a low-going pulse on the SMI line, the SCI line or both. The SMI line announces only the first event: it pulses when the SMI-pending flag goes from clear to set. The SCI line pulses on every update that carries any SCI-class event.

A separate one-cycle SCI request pulses the SCI line once for each command or data handshake on the ACPI channel. Each pulse holds its line low for a fixed number of clock cycles, long enough for a host that samples at 32.768 kHz to see it. A trigger that arrives while a pulse or its recovery gap is still running is latched and replayed as one further pulse. The wake line is a level. It is low whenever the wake-class vector, with the power-button bit removed, is non-zero.

Updates are ignored until the init-done input is high. The wake level and the SCI request work at all times.

Top module: `hev_notify`

## Requirements
- R1: On an accepted update where the SMI vector is non-zero and `smi_pend` was 0 before it, `smi_n` starts exactly one low pulse. If `smi_pend` was already 1, that update starts no SMI pulse.
- R2: On an accepted update, `smi_pend` becomes 1 if the SMI vector is non-zero and 0 otherwise, and `sci_pend` does the same for the SCI vector. The new values are visible in the cycle after the update.
- R3: Every accepted update whose SCI vector is non-zero requests one SCI pulse, whatever the previous value of `sci_pend`.
- R4: A pulse drives its line (`smi_n` or `sci_n`) low for exactly `PULSE_CYC` consecutive cycles. It starts in the cycle after the triggering edge, and the line then returns high.
- R5: `wake_n` is 0 one cycle after `wake_events` with bit `PWRBTN_BIT` cleared is non-zero, and 1 otherwise. Bit `PWRBTN_BIT` alone never drives it low. It does not depend on `init_done`.
- R6: A one-cycle `sci_req` pulse requests one SCI pulse, with or without `init_done`.
- R7: A request that arrives while a line is low or within its `GAP_CYC`-cycle recovery gap is held. It issues one further pulse once the line has been high for exactly `GAP_CYC` cycles. Any number of requests in that window merge into that one pulse.
- R8: While `init_done` is 0, `update` changes neither flag and starts no pulse.
- R9: After reset, `smi_n`, `sci_n` and `wake_n` are 1 and both pending flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_done | input | 1 | Enables acceptance of `update` |
| update | input | 1 | One-cycle strobe that samples the SMI and SCI vectors |
| smi_events | input | EV_W | Masked SMI-class event vector |
| sci_events | input | EV_W | Masked SCI-class event vector |
| wake_events | input | EV_W | Masked wake-class event vector |
| sci_req | input | 1 | One-cycle SCI request from the ACPI handshake |
| smi_n | output | 1 | Active-low SMI pulse line |
| sci_n | output | 1 | Active-low SCI pulse line |
| wake_n | output | 1 | Active-low wake level |
| smi_pend | output | 1 | SMI-class events present at the last accepted update |
| sci_pend | output | 1 | SCI-class events present at the last accepted update |

## Verification
A stale SMI pending flag shows at the ports within one update. It produces either a missing first-event pulse or a repeated one, and the pending flag output differs in the next cycle. A timer state that is off by one shows as a low run of the wrong length or as a recovery gap of the wrong length. Both are visible at the pulse's rising edge or at the next falling edge. A lost latched request shows as a missing second SCI pulse within one pulse length plus one gap.

// File: rtl/hev_pkg.sv
package hev_pkg;

    typedef enum logic [1:0] {
        PG_IDLE = 2'd0,
        PG_LOW  = 2'd1,
        PG_GAP  = 2'd2
    } pg_state_e;

    localparam int CH_SMI = 0;
    localparam int CH_SCI = 1;
    localparam int N_CH   = 2;

endpackage

// File: rtl/hev_pulse_gen.sv
module hev_pulse_gen
    import hev_pkg::*;
#(
    parameter int PULSE_CYC = 3120,
    parameter int GAP_CYC   = 48
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic line_n
);
    localparam int MAXC = (PULSE_CYC > GAP_CYC) ? PULSE_CYC : GAP_CYC;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] LOW_LAST = CW'(PULSE_CYC - 1);
    localparam logic [CW-1:0] GAP_LAST = CW'(GAP_CYC - 1);

    typedef struct packed {
        pg_state_e       st;
        logic [CW-1:0]   cnt;
        logic            pend;
        logic            line_n;
    } pg_s;

    pg_s q, d;

    always_comb begin
        d = q;
        unique case (q.st)
            PG_IDLE: begin
                if (trig) begin
                    d.st     = PG_LOW;
                    d.cnt    = '0;
                    d.line_n = 1'b0;
                end
            end
            PG_LOW: begin
                if (trig) d.pend = 1'b1;
                if (q.cnt == LOW_LAST) begin
                    d.st     = PG_GAP;
                    d.cnt    = '0;
                    d.line_n = 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            PG_GAP: begin
                if (q.cnt == GAP_LAST) begin
                    d.cnt  = '0;
                    d.pend = 1'b0;
                    if (q.pend || trig) begin
                        d.st     = PG_LOW;
                        d.line_n = 1'b0;
                    end else begin
                        d.st = PG_IDLE;
                    end
                end else begin
                    d.cnt = q.cnt + 1'b1;
                    if (trig) d.pend = 1'b1;
                end
            end
            default: begin
                d.st     = PG_IDLE;
                d.line_n = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st     <= PG_IDLE;
            q.cnt    <= '0;
            q.pend   <= 1'b0;
            q.line_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign line_n = q.line_n;

endmodule

// File: rtl/hev_event_track.sv
module hev_event_track
    import hev_pkg::*;
#(
    parameter int EV_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            init_done,
    input  logic            update,
    input  logic [EV_W-1:0] smi_events,
    input  logic [EV_W-1:0] sci_events,
    input  logic            sci_req,
    output logic            smi_pend,
    output logic            sci_pend,
    output logic [N_CH-1:0] trig
);
    typedef struct packed {
        logic smi_pend;
        logic sci_pend;
    } flag_s;

    flag_s q, d;
    logic  accept;
    logic  smi_any;
    logic  sci_any;

    always_comb begin
        accept  = update && init_done;
        smi_any = |smi_events;
        sci_any = |sci_events;
        d       = q;
        trig    = '0;
        if (accept) begin
            d.smi_pend = smi_any;
            d.sci_pend = sci_any;
        end
        trig[CH_SMI] = accept && smi_any && !q.smi_pend;
        trig[CH_SCI] = (accept && sci_any) || sci_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign smi_pend = q.smi_pend;
    assign sci_pend = q.sci_pend;

endmodule

// File: rtl/hev_wake_level.sv
module hev_wake_level #(
    parameter int EV_W       = 32,
    parameter int PWRBTN_BIT = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [EV_W-1:0] wake_events,
    output logic            wake_n
);
    localparam logic [EV_W-1:0] KEEP_MASK = ~(EV_W'(1) << PWRBTN_BIT);

    logic wake_n_d, wake_n_q;

    always_comb begin
        wake_n_d = ~|(wake_events & KEEP_MASK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wake_n_q <= 1'b1;
        end else begin
            wake_n_q <= wake_n_d;
        end
    end

    assign wake_n = wake_n_q;

endmodule

// File: rtl/hev_notify.sv
module hev_notify
    import hev_pkg::*;
#(
    parameter int EV_W       = 32,
    parameter int PWRBTN_BIT = 2,
    parameter int PULSE_CYC  = 3120,
    parameter int GAP_CYC    = 48
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            init_done,
    input  logic            update,
    input  logic [EV_W-1:0] smi_events,
    input  logic [EV_W-1:0] sci_events,
    input  logic [EV_W-1:0] wake_events,
    input  logic            sci_req,
    output logic            smi_n,
    output logic            sci_n,
    output logic            wake_n,
    output logic            smi_pend,
    output logic            sci_pend
);
    logic [N_CH-1:0] trig;
    logic [N_CH-1:0] line_n;

    hev_event_track #(.EV_W(EV_W)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .init_done  (init_done),
        .update     (update),
        .smi_events (smi_events),
        .sci_events (sci_events),
        .sci_req    (sci_req),
        .smi_pend   (smi_pend),
        .sci_pend   (sci_pend),
        .trig       (trig)
    );

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_line
        hev_pulse_gen #(
            .PULSE_CYC (PULSE_CYC),
            .GAP_CYC   (GAP_CYC)
        ) u_pulse (
            .clk    (clk),
            .rst_n  (rst_n),
            .trig   (trig[ch]),
            .line_n (line_n[ch])
        );
    end

    hev_wake_level #(
        .EV_W       (EV_W),
        .PWRBTN_BIT (PWRBTN_BIT)
    ) u_wake (
        .clk         (clk),
        .rst_n       (rst_n),
        .wake_events (wake_events),
        .wake_n      (wake_n)
    );

    assign smi_n = line_n[CH_SMI];
    assign sci_n = line_n[CH_SCI];

endmodule

// File: rtl/hev_notify_chk.sv
module hev_notify_chk #(
    parameter int EV_W       = 32,
    parameter int PWRBTN_BIT = 2,
    parameter int PULSE_CYC  = 3120,
    parameter int GAP_CYC    = 48
) (
    input logic            clk,
    input logic            rst_n,
    input logic            init_done,
    input logic            update,
    input logic [EV_W-1:0] smi_events,
    input logic [EV_W-1:0] sci_events,
    input logic [EV_W-1:0] wake_events,
    input logic            smi_n,
    input logic            sci_n,
    input logic            wake_n,
    input logic            smi_pend,
    input logic            sci_pend
);
    localparam logic [EV_W-1:0] KEEP_MASK = ~(EV_W'(1) << PWRBTN_BIT);

    logic [31:0] smi_lo, sci_lo, sci_hi;
    logic        sci_seen;
    logic        ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smi_lo   <= '0;
            sci_lo   <= '0;
            sci_hi   <= '0;
            sci_seen <= 1'b0;
            ready    <= 1'b0;
        end else begin
            smi_lo   <= smi_n ? 32'd0 : smi_lo + 32'd1;
            sci_lo   <= sci_n ? 32'd0 : sci_lo + 32'd1;
            sci_hi   <= sci_n ? sci_hi + 32'd1 : 32'd0;
            sci_seen <= sci_seen || !sci_n;
            ready    <= 1'b1;
        end
    end

    // R4: low run of smi_n never exceeds the pulse length
    a_r4_smi_max: assert property (@(posedge clk) disable iff (!rst_n)
        !smi_n |-> smi_lo < PULSE_CYC);

    // R4: smi_n returns high only after a full pulse length
    a_r4_smi_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(smi_n) |-> smi_lo == PULSE_CYC);

    // R4: sci_n returns high only after a full pulse length
    a_r4_sci_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sci_n) |-> sci_lo == PULSE_CYC);

    // R7: a following SCI pulse keeps the recovery gap
    a_r7_sci_gap: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sci_n) && sci_seen) |-> sci_hi >= GAP_CYC);

    // R2: flags follow the vectors of an accepted update
    a_r2_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (update && init_done) |=> (smi_pend == $past(|smi_events)) &&
                                  (sci_pend == $past(|sci_events)));

    // R8: flags hold when no update is accepted
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(update && init_done) |=> $stable(smi_pend) && $stable(sci_pend));

    // R5: wake level tracks the masked wake vector
    a_r5_wake: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> wake_n == !$past(|(wake_events & KEEP_MASK)));

endmodule

bind hev_notify hev_notify_chk #(
    .EV_W       (EV_W),
    .PWRBTN_BIT (PWRBTN_BIT),
    .PULSE_CYC  (PULSE_CYC),
    .GAP_CYC    (GAP_CYC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .init_done   (init_done),
    .update      (update),
    .smi_events  (smi_events),
    .sci_events  (sci_events),
    .wake_events (wake_events),
    .smi_n       (smi_n),
    .sci_n       (sci_n),
    .wake_n      (wake_n),
    .smi_pend    (smi_pend),
    .sci_pend    (sci_pend)
);

// File: tb/sim_hev_notify.sv
`timescale 1ns/1ps
module sim_hev_notify;
    localparam int EV_W = 32;
    localparam int PB   = 2;
    localparam int P    = 20;
    localparam int G    = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic init_done = 1'b0;
    logic update = 1'b0;
    logic sci_req = 1'b0;
    logic [EV_W-1:0] smi_events = '0;
    logic [EV_W-1:0] sci_events = '0;
    logic [EV_W-1:0] wake_events = '0;
    logic smi_n, sci_n, wake_n, smi_pend, sci_pend;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    hev_notify #(.EV_W(EV_W), .PWRBTN_BIT(PB), .PULSE_CYC(P), .GAP_CYC(G)) u0 (
        .clk(clk), .rst_n(rst_n), .init_done(init_done), .update(update),
        .smi_events(smi_events), .sci_events(sci_events),
        .wake_events(wake_events), .sci_req(sci_req),
        .smi_n(smi_n), .sci_n(sci_n), .wake_n(wake_n),
        .smi_pend(smi_pend), .sci_pend(sci_pend));

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Behavioural reference model
    int  m_lo [2];
    int  m_gp [2];
    bit  m_q  [2];
    bit  m_smi_pend, m_sci_pend, m_wake_n;

    function automatic bit m_line_n(input int c);
        return !(m_lo[c] > 0);
    endfunction

    always @(posedge clk) begin
        bit t [2];
        bit acc;
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin m_lo[c] = 0; m_gp[c] = 0; m_q[c] = 0; end
            m_smi_pend = 0; m_sci_pend = 0; m_wake_n = 1;
        end else begin
            acc  = update && init_done;
            t[0] = acc && (smi_events != 0) && !m_smi_pend;
            t[1] = (acc && (sci_events != 0)) || sci_req;
            if (acc) begin
                m_smi_pend = (smi_events != 0);
                m_sci_pend = (sci_events != 0);
            end
            m_wake_n = ((wake_events & ~(32'd1 << PB)) == 0);
            for (int c = 0; c < 2; c++) begin
                if (m_lo[c] > 0) begin
                    if (t[c]) m_q[c] = 1;
                    m_lo[c]--;
                    if (m_lo[c] == 0) m_gp[c] = G;
                end else if (m_gp[c] > 0) begin
                    m_gp[c]--;
                    if (m_gp[c] == 0) begin
                        if (m_q[c] || t[c]) m_lo[c] = P;
                        m_q[c] = 0;
                    end else if (t[c]) begin
                        m_q[c] = 1;
                    end
                end else if (t[c]) begin
                    m_lo[c] = P;
                end
            end
        end
    end

    // Per-cycle comparison and edge monitors
    int smi_lows = 0, smi_falls = 0, sci_falls = 0, sci_hi_run = 0, sci_last_gap = -1;
    bit p_smi = 1, p_sci = 1;
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R1/R4 smi_n vs model", smi_n, m_line_n(0));
            chk("R3/R6/R7 sci_n vs model", sci_n, m_line_n(1));
            chk("R5 wake_n vs model", wake_n, m_wake_n);
            chk("R2 smi_pend vs model", smi_pend, m_smi_pend);
            chk("R2 sci_pend vs model", sci_pend, m_sci_pend);
            if (!smi_n) smi_lows++;
            if (p_smi && !smi_n) smi_falls++;
            if (p_sci && !sci_n) begin sci_falls++; sci_last_gap = sci_hi_run; end
            sci_hi_run = sci_n ? sci_hi_run + 1 : 0;
            p_smi = smi_n;
            p_sci = sci_n;
        end
    end

    task automatic tick(input int n = 1);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic clr_mon();
        smi_lows = 0; smi_falls = 0; sci_falls = 0;
    endtask

    task automatic do_update(input logic [EV_W-1:0] smi, input logic [EV_W-1:0] sci);
        smi_events = smi; sci_events = sci; update = 1'b1;
        tick();
        update = 1'b0;
    endtask

    initial begin
        tick(3);
        chk("R9 reset smi_n", smi_n, 1);
        chk("R9 reset sci_n", sci_n, 1);
        chk("R9 reset wake_n", wake_n, 1);
        chk("R9 reset flags", {smi_pend, sci_pend}, 0);
        rst_n = 1'b1;
        tick(2);

        // R8: update without init_done
        clr_mon();
        do_update(32'h1, 32'h8);
        tick(30);
        chk("R8 flags unchanged", {smi_pend, sci_pend}, 0);
        chk("R8 no pulses", smi_falls + sci_falls, 0);

        // R6: SCI request without init_done
        clr_mon();
        sci_req = 1'b1; tick(); sci_req = 1'b0;
        tick(30);
        chk("R6 one sci pulse from request", sci_falls, 1);

        // R1, R4: first SMI event
        init_done = 1'b1;
        clr_mon();
        do_update(32'h1, 32'h0);
        tick(30);
        chk("R1 first smi pulse", smi_falls, 1);
        chk("R4 smi low width", smi_lows, P);
        chk("R2 smi_pend set", smi_pend, 1);

        // R1: flag already set, no pulse
        clr_mon();
        do_update(32'h10, 32'h0);
        tick(30);
        chk("R1 no repeat smi pulse", smi_falls, 0);

        // R2: clear then re-arm
        do_update(32'h0, 32'h0);
        chk("R2 smi_pend cleared", smi_pend, 0);
        clr_mon();
        do_update(32'h80000000, 32'h0);
        tick(30);
        chk("R1 smi pulse after rearm", smi_falls, 1);

        // R3, R7: SCI on every update, second latched behind the first
        clr_mon();
        do_update(32'h80000000, 32'h2);
        tick(3);
        do_update(32'h80000000, 32'h4);
        sci_req = 1'b1; tick(); sci_req = 1'b0;
        tick(70);
        chk("R3/R7 merged sci pulses", sci_falls, 2);
        chk("R7 recovery gap", sci_last_gap, G);
        chk("R2 sci_pend set", sci_pend, 1);
        chk("R1 no smi pulse while pending", smi_falls, 0);

        // R2: empty SCI vector
        clr_mon();
        do_update(32'h80000000, 32'h0);
        tick(30);
        chk("R2 sci_pend cleared", sci_pend, 0);
        chk("R3 no sci pulse when empty", sci_falls, 0);

        // R5: wake level
        wake_events = 32'h1 << PB; tick(2);
        chk("R5 power-button bit ignored", wake_n, 1);
        wake_events = (32'h1 << PB) | 32'h20; tick(2);
        chk("R5 wake low", wake_n, 0);
        wake_events = 32'h0; tick(2);
        chk("R5 wake released", wake_n, 1);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule